// File: doc/BRIEF.md
# Serial Command Decoder for a Digitally Controlled Resistor

This block is the serial front end of a digitally controlled resistor. An external controller frames a transfer by pulling an active-low select line low and clocking 16-bit words in on the rising serial-clock edge, most significant bit first. When the select line returns high, the last 16 bits received are decoded. This happens only if the transfer held a whole number of 16-bit words and no non-volatile store is in progress. Each word carries a 4-bit command and a 10-bit data field.

The decoder holds the 10-bit wiper code, a small control register and a shutdown flag. It sends one-cycle store and refresh requests to a separate non-volatile store sequencer, and that sequencer loads a recalled code back into the wiper. A read command does not answer in its own transfer. The 16-bit answer goes out on the serial data output during the next transfer, most significant bit first.

All serial pins are sampled on the system clock, which must run at least four times faster than the serial clock. The serial pins are assumed to be synchronous to the system clock already.

Top module: `dpot_spi_decoder`

## Requirements
- R1: After a synchronous active-low reset the outputs are as follows: `wiper` equals `WIPER_RST` (default 512), `ctrl` is 0, `shutdown` is 0, `store_req` and `refresh_req` are 0, and `sdo` is 0.
- R2: A word is shifted in MSB first on rising `sclk` while `sync_n` is low, and it is decoded when `sync_n` rises. Bits 13:10 are the command, bits 9:0 are the data, and bits 15:14 are ignored. Command 1 copies the data into `wiper`, and the all-zero code (terminal B) is accepted like any other value.
- R3: If a transfer ends after a bit count that is not a positive multiple of 16, it is discarded and no register changes. If a transfer is longer than 16 bits and its length is a multiple of 16, only its last 16 bits are decoded.
- R4: Commands 2, 7 and 5 queue a readback of the wiper code, the control register or `nv_rdata` (sampled at decode). The readback word has bits 15:10 at zero and the value in the low bits. It is driven on `sdo` MSB first during the next transfer and changes after falling `sclk`, so it is valid at each rising `sclk`.
- R5: When no readback is pending, `sdo` is 0 throughout a transfer.
- R6: Command 6 loads data bits `CTRL_W`-1:0 into `ctrl`.
- R7: Command 8 sets `shutdown` to data bit 0, where 1 means shutdown and 0 means normal operation.
- R8: Command 3 raises `store_req` for exactly one cycle, and command 4 raises `refresh_req` for exactly one cycle. A cycle with `nv_load_valid` high copies `nv_load_data` into `wiper`.
- R9: A transfer that ends while `nv_busy` is high is discarded and changes no register.
- R10: `sclk` edges while `sync_n` is high are ignored and do not disturb the alignment of the next transfer.
- R11: Command 0 and commands 9 to 15 change no register and queue no readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Transfer select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| nv_busy | input | 1 | Non-volatile store in progress |
| nv_rdata | input | 10 | Non-volatile content or status for readback |
| nv_load_valid | input | 1 | Recalled code is valid this cycle |
| nv_load_data | input | 10 | Recalled wiper code |
| store_req | output | 1 | One-cycle request to store the wiper code |
| refresh_req | output | 1 | One-cycle request to recall the stored code |
| wiper | output | 10 | Wiper code |
| ctrl | output | CTRL_W | Control register |
| shutdown | output | 1 | Shutdown flag |

## Verification
The bench sends 15-bit and 17-bit transfers that carry a valid wiper write. A decoder that counted bits loosely would change the wiper on either of them. It also sends a 32-bit transfer holding two different writes, and the first value appearing would show that the decoder took the wrong word. Readbacks are compared one transfer late, and the transfer after each readback must carry all zeros. A decoder that answered in the same transfer, or kept a stale answer pending, would mismatch there. Further cases check that `sclk` toggled while `sync_n` is high does not shift the next word, that a write during `nv_busy` is dropped, and that the unused command codes leave every register alone.

// File: rtl/dpot_pkg.sv
// Package: shared widths and command codes of the serial decoder.
// Assumes the word layout: 2 ignored bits, 4 command bits, 10 data bits.
package dpot_pkg;
    localparam int WORD_W = 16;
    localparam int CMD_W  = 4;
    localparam int DATA_W = 10;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP      = 4'd0,
        CMD_WR_WIPER = 4'd1,
        CMD_RD_WIPER = 4'd2,
        CMD_STORE    = 4'd3,
        CMD_REFRESH  = 4'd4,
        CMD_RD_NV    = 4'd5,
        CMD_WR_CTRL  = 4'd6,
        CMD_RD_CTRL  = 4'd7,
        CMD_SHDN     = 4'd8
    } dpot_cmd_e;
endpackage

// File: rtl/dpot_serial_rx.sv
// Module: serial receiver. Samples sync_n/sclk/din on clk and shifts on rising sclk
// inside a transfer. When sync_n rises, it flags a word as valid if the bit count is
// a positive multiple of WORD_W and the store is not busy.
// Assumes: inputs synchronous to clk, WORD_W a power of two, clk >= 4x sclk.
module dpot_serial_rx
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              nv_busy,
    output logic [WORD_W-1:0] word,
    output logic              word_ok,
    output logic              sclk_fall,
    output logic              sync_fall,
    output logic              sync_rise
);
    localparam int CNT_W = $clog2(WORD_W);

    logic             sclk_q, sclk_qq, sync_q, sync_qq, din_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             got_bits;
    logic             sclk_rise;

    // Register the serial pins once and keep a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            sync_q  <= 1'b1;
            sync_qq <= 1'b1;
            din_q   <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            sync_q  <= sync_n;
            sync_qq <= sync_q;
            din_q   <= din;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_qq & ~sync_q;
    assign sclk_fall = ~sclk_q & sclk_qq & ~sync_q;
    assign sync_fall = ~sync_q & sync_qq;
    assign sync_rise = sync_q & ~sync_qq;

    // Shift data and count bits within a transfer; restart the count on each new transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word     <= '0;
            bit_cnt  <= '0;
            got_bits <= 1'b0;
        end else if (sync_fall) begin
            bit_cnt  <= '0;
            got_bits <= 1'b0;
        end else if (sclk_rise) begin
            word     <= {word[WORD_W-2:0], din_q};
            bit_cnt  <= bit_cnt + 1'b1;
            got_bits <= 1'b1;
        end
    end

    // Qualify the received word when the transfer closes.
    always_ff @(posedge clk) begin
        if (!rst_n) word_ok <= 1'b0;
        else        word_ok <= sync_rise && got_bits && (bit_cnt == '0) && !nv_busy;
    end

    // R2
    // word_ok_pulse_chk: a word is decoded at most once per transfer close
    word_ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok |=> !word_ok);
endmodule

// File: rtl/dpot_cmd_exec.sv
// Module: command executor. Applies one decoded word to the wiper, control and
// shutdown state. It issues store and refresh pulses and builds readback words.
// Assumes word_ok is a single-cycle strobe.
module dpot_cmd_exec
    import dpot_pkg::*;
#(
    parameter int               CTRL_W    = 3,
    parameter logic [DATA_W-1:0] WIPER_RST = 10'd512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_ok,
    input  logic [13:0]       word_lo,
    input  logic [DATA_W-1:0] nv_rdata,
    input  logic              nv_load_valid,
    input  logic [DATA_W-1:0] nv_load_data,
    output logic [DATA_W-1:0] wiper,
    output logic [CTRL_W-1:0] ctrl,
    output logic              shutdown,
    output logic              store_req,
    output logic              refresh_req,
    output logic              rd_load,
    output logic [WORD_W-1:0] rd_word
);
    dpot_cmd_e         cmd;
    logic [DATA_W-1:0] data;

    assign cmd  = dpot_cmd_e'(word_lo[DATA_W+CMD_W-1:DATA_W]);
    assign data = word_lo[DATA_W-1:0];

    // Update state registers from a decoded command or a recalled code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper       <= WIPER_RST;
            ctrl        <= '0;
            shutdown    <= 1'b0;
            store_req   <= 1'b0;
            refresh_req <= 1'b0;
            rd_load     <= 1'b0;
            rd_word     <= '0;
        end else begin
            store_req   <= 1'b0;
            refresh_req <= 1'b0;
            rd_load     <= 1'b0;
            if (nv_load_valid) wiper <= nv_load_data;
            if (word_ok) begin
                case (cmd)
                    CMD_WR_WIPER: wiper <= data;
                    CMD_RD_WIPER: begin
                        rd_load <= 1'b1;
                        rd_word <= WORD_W'(wiper);
                    end
                    CMD_STORE:    store_req   <= 1'b1;
                    CMD_REFRESH:  refresh_req <= 1'b1;
                    CMD_RD_NV: begin
                        rd_load <= 1'b1;
                        rd_word <= WORD_W'(nv_rdata);
                    end
                    CMD_WR_CTRL:  ctrl <= data[CTRL_W-1:0];
                    CMD_RD_CTRL: begin
                        rd_load <= 1'b1;
                        rd_word <= WORD_W'(ctrl);
                    end
                    CMD_SHDN:     shutdown <= data[0];
                    default: ;
                endcase
            end
        end
    end

    // R8
    // store_pulse_chk: store request lasts one cycle
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R8
    // refresh_pulse_chk: refresh request lasts one cycle
    refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);

    // R4
    // rd_hi_zero_chk: readback upper bits are always zero
    rd_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> (rd_word[WORD_W-1:DATA_W] == '0));
endmodule

// File: rtl/dpot_sdo_tx.sv
// Module: readback shifter. Holds a pending readback word and loads it when a
// transfer opens. It shifts the word out MSB first after each falling sclk.
// Assumes: the strobes come from the receiver's sampled edges.
module dpot_sdo_tx
    import dpot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              sync_fall,
    input  logic              sync_rise,
    input  logic              sclk_fall,
    output logic              sdo
);
    logic [WORD_W-1:0] pend_word;
    logic              pend_valid;
    logic [WORD_W-1:0] tx_shift;

    // Keep the latest readback until the next transfer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_word  <= '0;
            pend_valid <= 1'b0;
        end else if (rd_load) begin
            pend_word  <= rd_word;
            pend_valid <= 1'b1;
        end else if (sync_fall) begin
            pend_valid <= 1'b0;
        end
    end

    // Load at transfer start, shift on falling sclk, clear at transfer end.
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_shift <= '0;
        else if (sync_fall)  tx_shift <= pend_valid ? pend_word : '0;
        else if (sync_rise)  tx_shift <= '0;
        else if (sclk_fall)  tx_shift <= {tx_shift[WORD_W-2:0], 1'b0};
    end

    assign sdo = tx_shift[WORD_W-1];

    // R5
    // sdo_idle_chk: sdo low in the cycle after a transfer closes
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> !sdo);
endmodule

// File: rtl/dpot_spi_decoder.sv
// Module: top of the serial command decoder for a digitally controlled resistor.
// It connects the receiver, the command executor and the readback shifter.
// Assumes: serial pins synchronous to clk, and clk at least 4x the serial clock.
module dpot_spi_decoder
    import dpot_pkg::*;
#(
    parameter int               CTRL_W    = 3,
    parameter logic [DATA_W-1:0] WIPER_RST = 10'd512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              din,
    output logic              sdo,
    input  logic              nv_busy,
    input  logic [DATA_W-1:0] nv_rdata,
    input  logic              nv_load_valid,
    input  logic [DATA_W-1:0] nv_load_data,
    output logic              store_req,
    output logic              refresh_req,
    output logic [DATA_W-1:0] wiper,
    output logic [CTRL_W-1:0] ctrl,
    output logic              shutdown
);
    logic [WORD_W-1:0] word;
    logic              word_ok, sclk_fall, sync_fall, sync_rise;
    logic              rd_load;
    logic [WORD_W-1:0] rd_word;

    dpot_serial_rx i_rx (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
        .nv_busy(nv_busy), .word(word), .word_ok(word_ok),
        .sclk_fall(sclk_fall), .sync_fall(sync_fall), .sync_rise(sync_rise)
    );

    dpot_cmd_exec #(.CTRL_W(CTRL_W), .WIPER_RST(WIPER_RST)) i_exec (
        .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word_lo(word[13:0]),
        .nv_rdata(nv_rdata), .nv_load_valid(nv_load_valid),
        .nv_load_data(nv_load_data), .wiper(wiper), .ctrl(ctrl),
        .shutdown(shutdown), .store_req(store_req), .refresh_req(refresh_req),
        .rd_load(rd_load), .rd_word(rd_word)
    );

    dpot_sdo_tx i_tx (
        .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_word(rd_word),
        .sync_fall(sync_fall), .sync_rise(sync_rise), .sclk_fall(sclk_fall),
        .sdo(sdo)
    );

    // R9
    // busy_lock_chk: while storing, only a recall may move state
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_busy && !nv_load_valid) |=> ($stable(wiper) && $stable(ctrl) && $stable(shutdown)));

    // R2
    // idle_stable_chk: with select high and no recall, the wiper holds
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n && $past(sync_n) && !nv_load_valid && !word_ok) |=> $stable(wiper));
endmodule

// File: tb/test_dpot_spi_decoder.sv
module test_dpot_spi_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       sdo;
    logic       nv_busy = 1'b0, nv_load_valid = 1'b0;
    logic [9:0] nv_rdata = '0, nv_load_data = '0;
    logic       store_req, refresh_req, shutdown;
    logic [9:0] wiper;
    logic [2:0] ctrl;

    int n_cmp = 0, n_bad = 0;
    int store_cnt = 0, refresh_cnt = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] cap;

    always #2 clk = ~clk;

    dpot_spi_decoder i_dpot_spi_decoder (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din), .sdo(sdo),
        .nv_busy(nv_busy), .nv_rdata(nv_rdata), .nv_load_valid(nv_load_valid),
        .nv_load_data(nv_load_data), .store_req(store_req), .refresh_req(refresh_req),
        .wiper(wiper), .ctrl(ctrl), .shutdown(shutdown)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // pulse counters
    always @(posedge clk) begin
        if (store_req)   store_cnt++;
        if (refresh_req) refresh_cnt++;
    end

    // monitor: capture sdo at rising sclk, compare at transfer close
    always @(posedge sclk) if (!sync_n) cap = {cap[14:0], sdo};
    always @(posedge sync_n) begin
        if (exp_q.size() > 0) begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, cap, e);
        end
    end

    task automatic xfer(input logic [47:0] bits, input int n);
        @(negedge clk) sync_n = 1'b0;
        cap = '0;
        for (int i = n - 1; i >= 0; i--) begin
            din = bits[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        sync_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // driver: one 16-bit word, with the sdo word expected during it
    task automatic send(input logic [3:0] c, input logic [9:0] d, input logic [15:0] exp_sdo,
                        input string tag);
        exp_q.push_back(exp_sdo);
        tag_q.push_back(tag);
        xfer({32'h0, 2'b00, c, d}, 16);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int sc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wiper", 16'(wiper), 16'd512);
        check("R1 ctrl", 16'(ctrl), 16'd0);
        check("R1 flags", {13'd0, shutdown, store_req, refresh_req}, 16'd0);
        check("R1 sdo", 16'(sdo), 16'd0);

        send(4'd1, 10'h155, 16'h0000, "R5 idle sdo");
        check("R2 write", 16'(wiper), 16'h0155);
        xfer({32'h0, 2'b11, 4'd1, 10'h2A7}, 16);
        check("R2 ignored top bits", 16'(wiper), 16'h02A7);
        send(4'd2, 10'h000, 16'h0000, "R5 no pending");
        send(4'd0, 10'h000, 16'h02A7, "R4 wiper readback");
        send(4'd0, 10'h000, 16'h0000, "R5 readback consumed");
        send(4'd1, 10'h000, 16'h0000, "R5 idle sdo");
        check("R2 terminal B code", 16'(wiper), 16'h0000);

        send(4'd6, 10'h3F5, 16'h0000, "R5 idle sdo");
        check("R6 ctrl", 16'(ctrl), 16'h0005);
        send(4'd7, 10'h000, 16'h0000, "R5 idle sdo");
        send(4'd0, 10'h000, 16'h0005, "R4 ctrl readback");

        send(4'd8, 10'h001, 16'h0000, "R5 idle sdo");
        check("R7 shutdown on", 16'(shutdown), 16'd1);
        send(4'd8, 10'h002, 16'h0000, "R5 idle sdo");
        check("R7 shutdown off", 16'(shutdown), 16'd0);

        sc = store_cnt;
        send(4'd3, 10'h000, 16'h0000, "R5 idle sdo");
        check("R8 store pulse", 16'(store_cnt - sc), 16'd1);
        sc = refresh_cnt;
        send(4'd4, 10'h000, 16'h0000, "R5 idle sdo");
        check("R8 refresh pulse", 16'(refresh_cnt - sc), 16'd1);
        @(negedge clk) begin nv_load_data = 10'h0AB; nv_load_valid = 1'b1; end
        @(negedge clk) nv_load_valid = 1'b0;
        check("R8 recall load", 16'(wiper), 16'h00AB);

        nv_rdata = 10'h3C1;
        send(4'd5, 10'h000, 16'h0000, "R5 idle sdo");
        nv_rdata = 10'h000;
        send(4'd0, 10'h000, 16'h03C1, "R4 nv readback");

        xfer({32'h0, 15'({2'b00, 4'd1, 10'h111} >> 1)}, 15);
        check("R3 15-bit dropped", 16'(wiper), 16'h00AB);
        xfer({31'h0, 1'b0, 2'b00, 4'd1, 10'h111}, 17);
        check("R3 17-bit dropped", 16'(wiper), 16'h00AB);
        xfer({16'h0, 2'b00, 4'd1, 10'h111, 2'b00, 4'd1, 10'h222}, 32);
        check("R3 32-bit last word", 16'(wiper), 16'h0222);

        @(negedge clk) nv_busy = 1'b1;
        xfer({32'h0, 2'b00, 4'd1, 10'h099}, 16);
        xfer({32'h0, 2'b00, 4'd6, 10'h002}, 16);
        check("R9 wiper locked", 16'(wiper), 16'h0222);
        check("R9 ctrl locked", 16'(ctrl), 16'h0005);
        @(negedge clk) nv_busy = 1'b0;

        for (int k = 0; k < 5; k++) begin
            @(negedge clk) begin sclk = 1'b1; din = 1'b1; end
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        send(4'd1, 10'h1C3, 16'h0000, "R5 idle sdo");
        check("R10 sclk with select high", 16'(wiper), 16'h01C3);

        for (int c = 9; c < 16; c++) begin
            send(4'(c), 10'h3FF, 16'h0000, "R11 no readback");
        end
        send(4'd0, 10'h3FF, 16'h0000, "R11 nop no readback");
        check("R11 wiper", 16'(wiper), 16'h01C3);
        check("R11 ctrl", 16'(ctrl), 16'h0005);
        check("R11 shutdown", 16'(shutdown), 16'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule